// File: doc/BRIEF.md
# Replicated Per-Cluster Register File

This block is the architectural register file of an N-wide core whose execution units are split into K clusters. It does not use one central array with 2N read ports. It keeps K identical copies of the registers, one per cluster. Each copy answers only the read requests of its own cluster, so it needs just 2N/K read ports. All N write ports are broadcast to every copy in the same cycle, and this keeps the copies identical.

Reads are combinational from the current contents. Writes take effect at the rising clock edge. So a read of a register that is being written in the same cycle returns the old value. Register 0 is hard-wired to zero. When several write ports target the same register in one cycle, the highest-numbered port wins, because it carries the youngest instruction. A synchronous active-low reset clears every copy.

Top module: `clustered_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register of every copy is cleared, so all read ports return zero afterwards.
- R2: An enabled write port p (bit p of `wr_en`) stores `wr_data[p*DW +: DW]` into register `wr_addr[p*AW +: AW]` at the rising edge. Every read of that register after the edge returns the value.
- R3: Every write reaches every cluster copy in the same cycle. A given register address reads the same value from all clusters at all times.
- R4: When several enabled write ports name the same register in one cycle, the port with the highest index determines the stored value.
- R5: A read of a register that is being written in the same cycle returns the value held before the edge.
- R6: Register 0 always reads zero. Writes to address 0 are discarded.
- R7: A write port whose enable bit is low changes nothing, whatever its address and data.
- R8: Read port q = c*RD + p is port p of cluster c, where RD = 2N/K. Its address is `rd_addr[q*AW +: AW]` and its data is `rd_data[q*DW +: DW]`. Each port returns the register its own address names, independently of the other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | N_WR | Per-port write enable |
| wr_addr | input | N_WR*AW | Write addresses, port p at bits p*AW |
| wr_data | input | N_WR*DW | Write data, port p at bits p*DW |
| rd_addr | input | N_CL*RD*AW | Read addresses, cluster-major |
| rd_data | output | N_CL*RD*DW | Read data, cluster-major |

## Verification
The bench builds the block with three write ports, two clusters (three read ports each), eight registers and 8-bit data. With these values every pair and the triple of colliding write ports can be swept over every non-zero register. The whole register space can also be read back from both clusters in three cycles. That makes it practical to compare the two copies with each other and with a bench model after every cycle of pseudo-random traffic.

// File: rtl/crf_pkg.sv
package crf_pkg;

  // read ports each cluster copy needs so that all copies together serve 2N reads
  function automatic int rd_ports_per_cluster(input int n_wr, input int n_cl);
    return (2 * n_wr) / n_cl;
  endfunction

  // address width for a register count
  function automatic int addr_bits(input int n_reg);
    return (n_reg <= 2) ? 1 : $clog2(n_reg);
  endfunction

  // bit offset of element idx in a flat vector of w-bit elements
  function automatic int slot_lo(input int idx, input int w);
    return idx * w;
  endfunction

endpackage

// File: rtl/crf_write_resolve.sv
module crf_write_resolve #(
  parameter int N_WR    = 4,
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int REG_IDX = 1
) (
  input  logic [N_WR-1:0]    wr_en,
  input  logic [N_WR*AW-1:0] wr_addr,
  input  logic [N_WR*DW-1:0] wr_data,
  output logic               hit,
  output logic [DW-1:0]      value
);

  // ascending scan: a later (younger) port overrides an earlier one
  always_comb begin
    hit   = 1'b0;
    value = '0;
    for (int p = 0; p < N_WR; p++) begin
      if (wr_en[p] && (wr_addr[p*AW +: AW] == AW'(REG_IDX))) begin
        hit   = 1'b1;
        value = wr_data[p*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/crf_replica.sv
module crf_replica #(
  parameter int N_WR  = 4,
  parameter int RD    = 4,
  parameter int N_REG = 32,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_WR-1:0]      wr_en,
  input  logic [N_WR*AW-1:0]   wr_addr,
  input  logic [N_WR*DW-1:0]   wr_data,
  input  logic [RD*AW-1:0]     rd_addr,
  output logic [RD*DW-1:0]     rd_data,
  output logic [N_REG*DW-1:0]  contents
);

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign contents[DW-1:0] = '0;
    end else begin : g_cell
      logic          hit;
      logic [DW-1:0] nxt;
      logic [DW-1:0] q;

      crf_write_resolve #(
        .N_WR(N_WR), .AW(AW), .DW(DW), .REG_IDX(r)
      ) resolve_i (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .hit    (hit),
        .value  (nxt)
      );

      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= nxt;
      end

      assign contents[crf_pkg::slot_lo(r, DW) +: DW] = q;
    end
  end

  for (genvar p = 0; p < RD; p++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = rd_addr[p*AW +: AW];
    assign rd_data[p*DW +: DW] =
      (32'(ra) < N_REG) ? contents[32'(ra)*DW +: DW] : '0;
  end

endmodule

// File: rtl/clustered_regfile.sv
module clustered_regfile #(
  parameter int N_WR  = 4,
  parameter int N_CL  = 2,
  parameter int N_REG = 32,
  parameter int DW    = 32,
  parameter int AW    = crf_pkg::addr_bits(N_REG),
  parameter int RD    = crf_pkg::rd_ports_per_cluster(N_WR, N_CL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_WR-1:0]        wr_en,
  input  logic [N_WR*AW-1:0]     wr_addr,
  input  logic [N_WR*DW-1:0]     wr_data,
  input  logic [N_CL*RD*AW-1:0]  rd_addr,
  output logic [N_CL*RD*DW-1:0]  rd_data
);

  localparam int COPY_W = N_REG * DW;

  // every copy's contents, brought out for the checker
  logic [N_CL*COPY_W-1:0] copies;

  for (genvar c = 0; c < N_CL; c++) begin : g_cluster
    crf_replica #(
      .N_WR(N_WR), .RD(RD), .N_REG(N_REG), .DW(DW), .AW(AW)
    ) replica_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr[c*RD*AW +: RD*AW]),
      .rd_data (rd_data[c*RD*DW +: RD*DW]),
      .contents(copies[c*COPY_W +: COPY_W])
    );
  end

endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
  parameter int N_WR  = 4,
  parameter int N_CL  = 2,
  parameter int N_REG = 32,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int RD    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_WR-1:0]             wr_en,
  input logic [N_WR*AW-1:0]          wr_addr,
  input logic [N_WR*DW-1:0]          wr_data,
  input logic [N_CL*RD*AW-1:0]       rd_addr,
  input logic [N_CL*RD*DW-1:0]       rd_data,
  input logic [N_CL*N_REG*DW-1:0]    copies
);

  localparam int COPY_W = N_REG * DW;

  function automatic logic [DW-1:0] copy0_at(input logic [N_CL*COPY_W-1:0] cp,
                                             input logic [AW-1:0] a);
    return cp[32'(a)*DW +: DW];
  endfunction

  logic copies_match;
  always_comb begin
    copies_match = 1'b1;
    for (int c = 1; c < N_CL; c++)
      if (copies[c*COPY_W +: COPY_W] != copies[COPY_W-1:0]) copies_match = 1'b0;
  end

  // a port "lands" when enabled, non-zero address, and no younger port hits the same register
  logic [N_WR-1:0] lands;
  always_comb begin
    for (int p = 0; p < N_WR; p++) begin
      lands[p] = wr_en[p] && (wr_addr[p*AW +: AW] != '0);
      for (int q = p + 1; q < N_WR; q++)
        if (wr_en[q] && (wr_addr[q*AW +: AW] == wr_addr[p*AW +: AW])) lands[p] = 1'b0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (copies == '0)); // R1
  AST_REPLICAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n) copies_match); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en == '0) |=> $stable(copies)); // R7

  for (genvar p = 0; p < N_WR; p++) begin : g_wp
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) lands[p] |=> (copy0_at(copies, $past(wr_addr[p*AW +: AW])) == $past(wr_data[p*DW +: DW]))); // R4
  end

  for (genvar q = 0; q < N_CL*RD; q++) begin : g_rp
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n) (rd_addr[q*AW +: AW] == '0) |-> (rd_data[q*DW +: DW] == '0)); // R6
  end

endmodule

bind clustered_regfile crf_checker #(
  .N_WR(N_WR), .N_CL(N_CL), .N_REG(N_REG), .DW(DW), .AW(AW), .RD(RD)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rd_addr(rd_addr),
  .rd_data(rd_data),
  .copies (copies)
);

// File: tb/clustered_regfile_tb_top.sv
`timescale 1ns/1ps
module clustered_regfile_tb_top;

  localparam int NW = 3;
  localparam int NC = 2;
  localparam int NR = 8;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int RD = 3;
  localparam int NP = NC * RD;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NW-1:0]     wr_en = '0;
  logic [NW*AW-1:0]  wr_addr = '0;
  logic [NW*DW-1:0]  wr_data = '0;
  logic [NP*AW-1:0]  rd_addr = '0;
  logic [NP*DW-1:0]  rd_data;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] model [NR];

  always #4 clk = ~clk;

  clustered_regfile #(.N_WR(NW), .N_CL(NC), .N_REG(NR), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                       input string tag, input int port);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s read port %0d got %h expected %h", tag, port, got, exp);
    end
  endtask

  // drive one cycle, check reads before the edge against the model, then apply writes to the model
  task automatic step(input logic [NW-1:0] en, input logic [NW*AW-1:0] wa,
                      input logic [NW*DW-1:0] wd, input logic [NP*AW-1:0] ra,
                      input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #1;
    for (int q = 0; q < NP; q++)
      check(rd_data[q*DW +: DW], model[ra[q*AW +: AW]], tag, q);
    @(posedge clk);
    for (int p = 0; p < NW; p++)
      if (en[p] && wa[p*AW +: AW] != '0) model[wa[p*AW +: AW]] = wd[p*DW +: DW];
  endtask

  // read every register from both clusters and compare the clusters with each other (R3)
  task automatic scan(input string tag);
    for (int chunk = 0; chunk < 3; chunk++) begin
      logic [NP*AW-1:0] ra;
      for (int i = 0; i < RD; i++) begin
        ra[i*AW +: AW]      = AW'((chunk * RD + i) % NR);
        ra[(RD+i)*AW +: AW] = AW'((chunk * RD + i) % NR);
      end
      step('0, '0, '0, ra, tag);
      for (int i = 0; i < RD; i++)
        check(rd_data[(RD+i)*DW +: DW], rd_data[i*DW +: DW], "R3", RD + i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = '0;
    repeat (3) @(posedge clk);
    for (int r = 0; r < NR; r++) model[r] = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [NP*AW-1:0] all_read(input int a);
    logic [NP*AW-1:0] v;
    for (int q = 0; q < NP; q++) v[q*AW +: AW] = AW'(a);
    return v;
  endfunction

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    do_reset();
    scan("R1");

    // R2: single writes spread across ports
    for (int a = 1; a < NR; a++) begin
      logic [NW-1:0] en; logic [NW*AW-1:0] wa; logic [NW*DW-1:0] wd;
      en = '0; wa = '0; wd = '0;
      en[a % NW] = 1'b1;
      wa[(a % NW)*AW +: AW] = AW'(a);
      wd[(a % NW)*DW +: DW] = DW'(a * 17 + 3);
      step(en, wa, wd, all_read(0), "R2");
    end
    scan("R2");

    // R8: every port reads a distinct register
    begin
      logic [NP*AW-1:0] ra;
      for (int q = 0; q < NP; q++) ra[q*AW +: AW] = AW'((q * 3 + 1) % NR);
      step('0, '0, '0, ra, "R8");
      for (int q = 0; q < NP; q++) ra[q*AW +: AW] = AW'(NR - 1 - q);
      step('0, '0, '0, ra, "R8");
    end

    // R4: every colliding port pair and the triple, on every non-zero register
    for (int mask = 3; mask < 8; mask++) begin
      if (mask == 4) continue;
      for (int a = 1; a < NR; a++) begin
        logic [NW*AW-1:0] wa; logic [NW*DW-1:0] wd;
        for (int p = 0; p < NW; p++) begin
          wa[p*AW +: AW] = AW'(a);
          wd[p*DW +: DW] = DW'(mask * 40 + a * 5 + p);
        end
        step(NW'(mask), wa, wd, all_read(a), "R4");
        step('0, '0, '0, all_read(a), "R4");
      end
    end

    // R5: read during write returns the old value, next cycle the new one
    for (int a = 1; a < NR; a++) begin
      logic [NW*AW-1:0] wa; logic [NW*DW-1:0] wd;
      wa = '0; wd = '0;
      wa[(NW-1)*AW +: AW] = AW'(a);
      wd[(NW-1)*DW +: DW] = DW'(8'hA0 + a);
      step(NW'(1 << (NW-1)), wa, wd, all_read(a), "R5");
      step('0, '0, '0, all_read(a), "R2");
    end

    // R6: writes to register 0 from every port are discarded
    step('1, '0, {NW{8'hFF}}, all_read(0), "R6");
    step('0, '0, '0, all_read(0), "R6");

    // R7: disabled ports with live address and data
    for (int i = 0; i < 20; i++)
      step('0, NW*AW'($urandom), NW*DW'($urandom), NP*AW'($urandom), "R7");
    scan("R7");

    // R3: pseudo-random traffic, full copy comparison after every cycle
    for (int i = 0; i < 400; i++) begin
      step(NW'($urandom), NW*AW'($urandom), NW*DW'($urandom), NP*AW'($urandom), "R3");
      scan("R3");
    end

    // R1: reset with non-zero contents
    do_reset();
    scan("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule